// File: doc/BRIEF.md
# Vectored Interrupt Controller

The block collects 32 level-sensitive interrupt sources and presents them to a processor on two lines: a fast interrupt line and a normal interrupt line. Every source carries an enable bit and a software-raise bit. Each of these two masks has a set address and a separate clear address. A select mask routes each source to one of the two lines. A source is pending while its hardware level is high or its software bit is set. A pending source reaches an output only when its enable bit is set.

Normal sources can be vectored. Sixteen slots each name one source and hold a handler address. Slot 0 has the highest priority. Enabled normal sources that no enabled slot names share a default address, which ranks below every slot. Software reads the current-vector register to fetch the handler address of the winning request. That read also marks the level as in service. While a level is in service, only strictly higher levels raise the normal line. A write of any value to the same register ends service of the most recent level, so nested handlers unwind in order. A set of read-only identification registers returns one byte each.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset all masks, the slots, the default address, the protection bit and the test register are zero. No level is in service, both interrupt outputs are low and read data is zero.
- R2: A write to 0x10 sets enable bits where the data has ones. A write to 0x14 clears enable bits where the data has ones. Zero bits in either write leave the mask unchanged. Reading 0x10 returns the mask, and a source whose enable bit is clear reaches neither output.
- R3: A write to 0x18 sets software-raise bits where the data has ones. A write to 0x1C clears them where the data has ones. Zero bits leave the mask unchanged. Reading 0x18 returns the mask.
- R4: Reading 0x08 returns hardware level OR software bit for every source. Reading 0x00 returns that value ANDed with enable and with the inverted select mask. Reading 0x04 returns it ANDed with enable and with the select mask.
- R5: In the select mask at 0x0C (read/write), a 1 routes the source to the fast line and a 0 routes it to the normal line. The fast line is high exactly when the value read at 0x04 would be nonzero. Fast sources take no part in vectoring.
- R6: Slot i has its handler address at 0x100+4i and its control word at 0x200+4i. In the control word, bit 5 enables the slot and bits 4:0 name the source. Reading a control word returns only those six bits.
- R7: A read of 0x30 returns the handler address of the lowest-numbered eligible enabled slot whose source is pending at 0x00. If no slot qualifies but an unclaimed normal source is pending, it returns the default address held at 0x34. With no eligible request it also returns the default address.
- R8: A read of 0x30 that finds an eligible request marks its level as in service (slots 0 to 15, default level 16). While levels are in service, the normal line and R7 consider only levels numbered below the most recent one.
- R9: A write of any value to 0x30 ends service of the most recently entered level. With no level in service the write has no effect.
- R10: A read and a write of 0x30 in the same cycle return the pre-write winner, end service of the old most recent level and enter the winner's level.
- R11: Reading 0xFE0+4i (i = 0..3) returns byte i of the 32-bit identification word in bits 7:0, least significant byte first. The vendor code sits in bits 19:12 of that word (default 0x41).
- R12: Bit 0 of 0x20 (protection) and the full word at 0x300 (test, 0 means normal operation) are stored and read back but do not affect the interrupt lines. Reads of unmapped or write-only addresses return 0, and writes to unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_lvl | input | 32 | Hardware interrupt levels |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe and held until the next read |
| norm_irq | output | 1 | Normal interrupt line |
| fast_irq | output | 1 | Fast interrupt line |

## Verification
Entry into service and end of service can happen in one cycle when a handler acknowledges with a write to the current-vector register while it also reads that register for a newly arrived, higher request. The bench drives both strobes together on that address while a nested level is already active. It then judges the returned address, the next state of the normal line and the vectors of later reads against a reference model that keeps a list of in-service levels. Random traffic mixes hardware level changes with software set and clear writes in the same cycle as vector reads, which tests that a request changing at an edge is decided on its pre-edge value.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int ADDR_W = 12;
  localparam int CTL_EN_BIT = 5;

  localparam logic [ADDR_W-1:0] OFS_NSTAT = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_FSTAT = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_SEL   = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_ENSET = 12'h010;
  localparam logic [ADDR_W-1:0] OFS_ENCLR = 12'h014;
  localparam logic [ADDR_W-1:0] OFS_SWSET = 12'h018;
  localparam logic [ADDR_W-1:0] OFS_SWCLR = 12'h01C;
  localparam logic [ADDR_W-1:0] OFS_PROT  = 12'h020;
  localparam logic [ADDR_W-1:0] OFS_CURV  = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_DEFV  = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_TEST  = 12'h300;

  localparam logic [3:0] PAGE_VADDR = 4'h1;
  localparam logic [3:0] PAGE_VCTL  = 4'h2;
  localparam logic [7:0] ID_HI      = 8'hFE;
endpackage

// File: rtl/irqv_pick.sv
module irqv_pick #(
  parameter int N = 17
) (
  input  logic [N-1:0]         req,
  input  logic [N-1:0]         allow,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx,
  output logic [N-1:0]         oh
);
  localparam int IW = $clog2(N);

  logic [N-1:0] elig;

  always_comb begin
    elig = req & allow;
    any  = |elig;
    idx  = '0;
    oh   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (elig[k]) begin
        idx   = IW'(k);
        oh    = '0;
        oh[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqv_nest.sv
module irqv_nest #(
  parameter int LV = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LV-1:0] push_oh,
  input  logic          pop,
  output logic [LV-1:0] allow
);
  logic [LV-1:0] act_q, act_d, top_oh;

  assign top_oh = act_q & (~act_q + LV'(1));

  always_comb begin
    act_d = act_q;
    if (pop)  act_d = act_d & ~top_oh;
    if (push) act_d = act_d | push_oh;
  end

  always_comb begin
    logic run;
    run = 1'b1;
    for (int k = 0; k < LV; k++) begin
      allow[k] = run & ~act_q[k];
      run      = allow[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assert_push_above_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((push_oh & ~allow) == '0));
  assert_push_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ($countones(push_oh) == 1));
  assert_pop_drops_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && act_q != '0) |=> ($countones(act_q) == $countones($past(act_q)) - 1));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irqv_pkg::*;
#(
  parameter int          NSRC    = 32,
  parameter int          NSLOT   = 16,
  parameter int          DW      = 32,
  parameter logic [31:0] ID_WORD = 32'h0004_1190
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_lvl,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     bus_rdata,
  output logic              norm_irq,
  output logic              fast_irq
);
  localparam int SRCW = $clog2(NSRC);
  localparam int LV   = NSLOT + 1;
  localparam int LVW  = $clog2(LV);
  localparam int SLW  = $clog2(NSLOT);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  logic [NSRC-1:0] sel_q, sel_d, en_q, en_d, soft_q, soft_d;
  logic            prot_q, prot_d;
  logic [DW-1:0]   defv_q, defv_d, tst_q, tst_d, rdata_q, rdata_d;

  logic [NSLOT-1:0][DW-1:0]   va_q;
  logic [NSLOT-1:0]           ce_q;
  logic [NSLOT-1:0][SRCW-1:0] cs_q;
  logic [NSLOT-1:0]           slot_req;

  logic [NSRC-1:0] raw, nstat, fstat, claimed;
  logic            def_req;
  logic [LV-1:0]   allow, win_oh;
  logic            win_any, do_push, do_pop;
  logic [LVW-1:0]  win_idx;
  logic [DW-1:0]   curv;

  assign raw   = src_lvl | soft_q;
  assign nstat = raw & en_q & ~sel_q;
  assign fstat = raw & en_q & sel_q;

  // global control registers: next state
  always_comb begin
    sel_d  = sel_q;
    en_d   = en_q;
    soft_d = soft_q;
    prot_d = prot_q;
    defv_d = defv_q;
    tst_d  = tst_q;
    if (bus_wr) begin
      case (bus_addr)
        OFS_SEL:   sel_d  = bus_wdata[NSRC-1:0];
        OFS_ENSET: en_d   = en_q | bus_wdata[NSRC-1:0];
        OFS_ENCLR: en_d   = en_q & ~bus_wdata[NSRC-1:0];
        OFS_SWSET: soft_d = soft_q | bus_wdata[NSRC-1:0];
        OFS_SWCLR: soft_d = soft_q & ~bus_wdata[NSRC-1:0];
        OFS_PROT:  prot_d = bus_wdata[0];
        OFS_DEFV:  defv_d = bus_wdata;
        OFS_TEST:  tst_d  = bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      en_q   <= '0;
      soft_q <= '0;
      prot_q <= 1'b0;
      defv_q <= '0;
      tst_q  <= '0;
    end else begin
      sel_q  <= sel_d;
      en_q   <= en_d;
      soft_q <= soft_d;
      prot_q <= prot_d;
      defv_q <= defv_d;
      tst_q  <= tst_d;
    end
  end

  // vector slots
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [DW-1:0]   va_r, va_n;
    logic            ce_r, ce_n;
    logic [SRCW-1:0] cs_r, cs_n;
    logic            hit_a, hit_c;

    assign hit_a = bus_wr && bus_addr[11:8] == PAGE_VADDR &&
                   bus_addr[7:2] == 6'(i) && bus_addr[1:0] == 2'b00;
    assign hit_c = bus_wr && bus_addr[11:8] == PAGE_VCTL &&
                   bus_addr[7:2] == 6'(i) && bus_addr[1:0] == 2'b00;

    always_comb begin
      va_n = va_r;
      ce_n = ce_r;
      cs_n = cs_r;
      if (hit_a) va_n = bus_wdata;
      if (hit_c) begin
        ce_n = bus_wdata[CTL_EN_BIT];
        cs_n = bus_wdata[SRCW-1:0];
      end
    end

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        va_r <= '0;
        ce_r <= 1'b0;
        cs_r <= '0;
      end else begin
        va_r <= va_n;
        ce_r <= ce_n;
        cs_r <= cs_n;
      end
    end

    assign va_q[i]     = va_r;
    assign ce_q[i]     = ce_r;
    assign cs_q[i]     = cs_r;
    assign slot_req[i] = ce_r & nstat[cs_r];
  end

  always_comb begin
    claimed = '0;
    for (int k = 0; k < NSLOT; k++)
      if (ce_q[k]) claimed[cs_q[k]] = 1'b1;
  end
  assign def_req = |(nstat & ~claimed);

  irqv_pick #(.N(LV)) u_pick (
    .req   ({def_req, slot_req}),
    .allow (allow),
    .any   (win_any),
    .idx   (win_idx),
    .oh    (win_oh)
  );

  assign do_push = bus_rd && bus_addr == OFS_CURV && win_any;
  assign do_pop  = bus_wr && bus_addr == OFS_CURV;

  irqv_nest #(.LV(LV)) u_nest (
    .clk     (clk),
    .rst_n   (rst_ni),
    .push    (do_push),
    .push_oh (win_oh),
    .pop     (do_pop),
    .allow   (allow)
  );

  assign curv = (win_any && win_idx != LVW'(NSLOT)) ? va_q[win_idx[SLW-1:0]] : defv_q;

  // read path
  always_comb begin
    logic [DW-1:0] v;
    logic [5:0]    sidx;
    sidx = bus_addr[7:2];
    v    = '0;
    case (bus_addr)
      OFS_NSTAT: v = DW'(nstat);
      OFS_FSTAT: v = DW'(fstat);
      OFS_RAW:   v = DW'(raw);
      OFS_SEL:   v = DW'(sel_q);
      OFS_ENSET: v = DW'(en_q);
      OFS_SWSET: v = DW'(soft_q);
      OFS_PROT:  v = DW'(prot_q);
      OFS_CURV:  v = curv;
      OFS_DEFV:  v = defv_q;
      OFS_TEST:  v = tst_q;
      default: begin
        if (bus_addr[1:0] == 2'b00) begin
          if (bus_addr[11:8] == PAGE_VADDR && sidx < 6'(NSLOT)) begin
            v = va_q[sidx[SLW-1:0]];
          end else if (bus_addr[11:8] == PAGE_VCTL && sidx < 6'(NSLOT)) begin
            v[CTL_EN_BIT] = ce_q[sidx[SLW-1:0]];
            v[SRCW-1:0]   = cs_q[sidx[SLW-1:0]];
          end else if (bus_addr[11:4] == ID_HI) begin
            v[7:0] = ID_WORD[8*bus_addr[3:2] +: 8];
          end
        end
      end
    endcase
    rdata_d = bus_rd ? v : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
  assign norm_irq  = win_any;
  assign fast_irq  = |fstat;

  assert_enclr_all_quiet_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && bus_addr == OFS_ENCLR && (&bus_wdata[NSRC-1:0])) |=> (!fast_irq && !norm_irq));
  assert_swset_takes_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && bus_addr == OFS_SWSET) |=>
      ((soft_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0])));
  assert_swclr_takes_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (bus_wr && bus_addr == OFS_SWCLR) |=> ((soft_q & $past(bus_wdata[NSRC-1:0])) == '0));
  assert_fast_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    fast_irq |-> ((sel_q & en_q) != '0));
endmodule

// File: tb/irq_vector_ctrl_test.sv
module irq_vector_ctrl_test;
  localparam logic [31:0] IDW = 32'h0004_1190;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        norm_irq, fast_irq;

  int    compared = 0, mismatched = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  irq_vector_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .norm_irq(norm_irq), .fast_irq(fast_irq)
  );

  // reference model
  logic [31:0] m_en, m_sel, m_soft, m_def, m_tst, m_rd;
  logic        m_prot;
  logic [31:0] m_va [16];
  logic        m_ce [16];
  int          m_cs [16];
  int          stk [$];

  function automatic logic [31:0] m_nst();
    return (src_lvl | m_soft) & m_en & ~m_sel;
  endfunction

  function automatic int m_win();
    logic [31:0] n;
    int top;
    n   = m_nst();
    top = (stk.size() > 0) ? stk[0] : 17;
    for (int i = 0; i < 16; i++)
      if (i < top && m_ce[i] && n[m_cs[i]]) return i;
    if (top > 16) begin
      for (int b = 0; b < 32; b++) begin
        bit owned = 1'b0;
        for (int i = 0; i < 16; i++) if (m_ce[i] && m_cs[i] == b) owned = 1'b1;
        if (n[b] && !owned) return 16;
      end
    end
    return -1;
  endfunction

  function automatic logic [31:0] m_read(logic [11:0] a, int w);
    logic [31:0] raw;
    raw = src_lvl | m_soft;
    case (a)
      12'h000: return raw & m_en & ~m_sel;
      12'h004: return raw & m_en & m_sel;
      12'h008: return raw;
      12'h00C: return m_sel;
      12'h010: return m_en;
      12'h018: return m_soft;
      12'h020: return {31'b0, m_prot};
      12'h030: return (w >= 0 && w < 16) ? m_va[w] : m_def;
      12'h034: return m_def;
      12'h300: return m_tst;
      default: ;
    endcase
    if (a[1:0] != 2'b00) return 0;
    if (a[11:8] == 4'h1 && a[7:2] < 16) return m_va[a[5:2]];
    if (a[11:8] == 4'h2 && a[7:2] < 16) return {26'b0, m_ce[a[5:2]], 5'(m_cs[a[5:2]])};
    if (a[11:4] == 8'hFE) return (IDW >> (8 * a[3:2])) & 32'hFF;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_soft = 0; m_def = 0; m_tst = 0; m_rd = 0; m_prot = 0;
      for (int i = 0; i < 16; i++) begin m_va[i] = 0; m_ce[i] = 0; m_cs[i] = 0; end
      stk.delete();
    end else begin
      int w;
      w = m_win();
      if (bus_rd) m_rd = m_read(bus_addr, w);
      if (bus_wr) begin
        case (bus_addr)
          12'h00C: m_sel = bus_wdata;
          12'h010: m_en = m_en | bus_wdata;
          12'h014: m_en = m_en & ~bus_wdata;
          12'h018: m_soft = m_soft | bus_wdata;
          12'h01C: m_soft = m_soft & ~bus_wdata;
          12'h020: m_prot = bus_wdata[0];
          12'h034: m_def = bus_wdata;
          12'h300: m_tst = bus_wdata;
          default: begin
            if (bus_addr[1:0] == 0 && bus_addr[11:8] == 4'h1 && bus_addr[7:2] < 16)
              m_va[bus_addr[5:2]] = bus_wdata;
            if (bus_addr[1:0] == 0 && bus_addr[11:8] == 4'h2 && bus_addr[7:2] < 16) begin
              m_ce[bus_addr[5:2]] = bus_wdata[5];
              m_cs[bus_addr[5:2]] = int'(bus_wdata[4:0]);
            end
          end
        endcase
        if (bus_addr == 12'h030 && stk.size() > 0) void'(stk.pop_front());
      end
      if (bus_rd && bus_addr == 12'h030 && w >= 0) stk.push_front(w);
    end
  end

  // comparison every cycle, away from the active edge
  always @(negedge clk) begin
    logic en, ef;
    en = (m_win() >= 0);
    ef = |((src_lvl | m_soft) & m_en & m_sel);
    compared += 3;
    if (norm_irq !== en) begin
      mismatched++;
      $display("FAIL %s norm_irq actual %b expected %b at %0t", cur_req, norm_irq, en, $time);
    end
    if (fast_irq !== ef) begin
      mismatched++;
      $display("FAIL %s fast_irq actual %b expected %b at %0t", cur_req, fast_irq, ef, $time);
    end
    if (bus_rdata !== m_rd) begin
      mismatched++;
      $display("FAIL %s bus_rdata actual %h expected %h at %0t", cur_req, bus_rdata, m_rd, $time);
    end
  end

  task automatic access(input logic [11:0] a, input logic [31:0] d, input bit r, input bit w);
    @(posedge clk); #2;
    bus_addr = a; bus_wdata = d; bus_rd = r; bus_wr = w;
    @(posedge clk); #2;
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d); access(a, d, 1'b0, 1'b1); endtask
  task automatic rd(input logic [11:0] a); access(a, 32'h0, 1'b1, 1'b0); endtask
  task automatic set_src(input logic [31:0] v); @(posedge clk); #2; src_lvl = v; endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    cur_req = "R1"; rd(12'h000); rd(12'h030);

    cur_req = "R2"; set_src(32'h0000_0005); rd(12'h000);
    wr(12'h010, 32'h0000_0001); rd(12'h010); rd(12'h000);
    wr(12'h010, 32'hF000_0000); wr(12'h014, 32'h1000_0001); rd(12'h010);

    cur_req = "R3"; wr(12'h018, 32'h8000_0001); wr(12'h018, 32'h0000_0002);
    wr(12'h01C, 32'h0000_0001); rd(12'h018);

    cur_req = "R4"; wr(12'h010, 32'hFFFF_FFFF); rd(12'h008); rd(12'h000); rd(12'h004);

    cur_req = "R5"; wr(12'h00C, 32'h8000_0004); rd(12'h004); rd(12'h000); rd(12'h00C);
    wr(12'h00C, 32'h0); wr(12'h01C, 32'hFFFF_FFFF); set_src(32'h0);

    cur_req = "R6";
    for (int i = 0; i < 16; i++) begin
      wr(12'(12'h100 + 4 * i), 32'h1000 + 32'(i) * 16);
      wr(12'(12'h200 + 4 * i), 32'h20 | 32'(i + 3));
    end
    wr(12'h23C, 32'hFFFF_FFC3); rd(12'h23C); rd(12'h108); rd(12'h214);
    wr(12'h034, 32'hDEF0_0000);

    cur_req = "R7"; set_src(32'h0000_0100); rd(12'h030);
    cur_req = "R8"; set_src(32'h0000_0120); rd(12'h030);
    set_src(32'h0000_0128); rd(12'h030);
    cur_req = "R9"; wr(12'h030, 32'h0); rd(12'h030); wr(12'h030, 32'h0); wr(12'h030, 32'h0);
    wr(12'h030, 32'h0);
    cur_req = "R7"; set_src(32'h0000_0001); rd(12'h030); wr(12'h030, 32'h0);
    set_src(32'h0); rd(12'h030);

    cur_req = "R10"; set_src(32'h0000_0100); rd(12'h030);
    set_src(32'h0000_0110); access(12'h030, 32'h0, 1'b1, 1'b1); rd(12'h030);
    wr(12'h030, 32'h0); wr(12'h030, 32'h0); set_src(32'h0);

    cur_req = "R11";
    for (int i = 0; i < 4; i++) rd(12'(12'hFE0 + 4 * i));

    cur_req = "R12"; wr(12'h020, 32'hFFFF_FFFF); rd(12'h020);
    wr(12'h300, 32'h0000_00FF); rd(12'h300); wr(12'h300, 32'h0);
    wr(12'h3F0, 32'hFFFF_FFFF); rd(12'h3F0); rd(12'h014); rd(12'h01C); rd(12'h032);

    cur_req = "R8";
    lf = 32'h1ACE_B00C;
    for (int n = 0; n < 500; n++) begin
      logic [11:0] a;
      logic [3:0]  k;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      k = lf[11:8];
      case (lf[3:0])
        4'd0: a = 12'h000;  4'd1: a = 12'h004;  4'd2: a = 12'h008;  4'd3: a = 12'h00C;
        4'd4: a = 12'h010;  4'd5: a = 12'h014;  4'd6: a = 12'h018;  4'd7: a = 12'h01C;
        4'd8, 4'd9, 4'd13: a = 12'h030;
        4'd10: a = 12'h034;
        4'd11: a = 12'(12'h100 + 4 * k);
        4'd12: a = 12'(12'h200 + 4 * k);
        4'd14: a = 12'(12'hFE0 + 4 * k[1:0]);
        default: a = 12'h300;
      endcase
      if (lf[13:12] == 2'b00) src_lvl = {lf[7:0], lf[31:24], lf[15:8], lf[23:16]} & {lf[27:20], 24'hFFFFFF};
      access(a, {lf[15:0], lf[31:16]}, lf[16] | lf[18], lf[17] | ~lf[16]);
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule